// File: doc/BRIEF.md
# Prioritized PCI Interrupt Aggregator

This block gathers level-sensitive interrupt requests from three PCI device slots and from the PCI host core. It folds them into one registered interrupt line toward the CPU and tells the handler which source to service first. Each request sets a bit in a status register. An enable register masks the status bits, and a fixed-priority encoder selects the lowest-numbered source among those still pending. Device 0 has the highest priority and the host core the lowest.

Software reaches both registers through a small synchronous register port. The port offers whole-word access to status and enable. It also offers two enable-update addresses, one that sets bits and one that clears bits, so that masking one source never needs a read-modify-write. When the CPU acknowledges the chained line and no source is pending, the block raises a one-cycle spurious flag.

Top module: `pci_irq_aggr`

## Requirements
- R1: Reset (synchronous, active high) clears the status and enable registers, `reg_rdata`, `cpu_irq`, `src_valid` and `spurious`.
- R2: The source bit map is fixed. Bits 0, 1 and 2 are device slots 0 to 2, and bit 4 is the host core. Bit 3 always reads as 0. A write to bit 3 has no effect, and a request on `irq_req[3]` is ignored.
- R3: Register addresses are 0 for status, 1 for enable, 2 for enable set-bits and 3 for enable clear-bits. A status bit becomes 1 in the clock after its request is high. Writing 1 to a status bit clears it, but the bit stays 1 while its request is still high.
- R4: A source is pending only when both its status bit and its enable bit are 1. `cpu_irq` is registered and equals the OR of the pending bits as they were one clock earlier.
- R5: `src_id` names the highest-priority pending source, one clock after the registers change. The order is 0, then 1, then 2, then 4, and the ID value equals the bit index.
- R6: When nothing is pending, `src_valid` and `cpu_irq` are 0 and `src_id` is 0.
- R7: A write to address 2 sets the enable bits that are 1 in `reg_wdata` and leaves every other enable bit unchanged.
- R8: A write to address 3 clears the enable bits that are 1 in `reg_wdata` and leaves every other enable bit unchanged.
- R9: A write to address 1 replaces the enable register. A read returns data on `reg_rdata` one clock after `reg_re`. Reads at addresses 1, 2 and 3 return the enable value, so a read that directly follows a write sees the updated value.
- R10: `int_ack` high while nothing is pending gives a one-clock pulse on `spurious` in the next cycle. `int_ack` high while a source is pending leaves `spurious` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Level interrupt requests, one per source bit |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 set, 3 clear) |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data, registered |
| int_ack | input | 1 | CPU acknowledge of the chained line |
| cpu_irq | output | 1 | Chained interrupt to the CPU, registered |
| src_valid | output | 1 | A source is pending |
| src_id | output | ID_W | Index of the source to service |
| spurious | output | 1 | Acknowledge seen with nothing pending |

## Verification
The assertions check several rules on every cycle. A pending bit always drives `cpu_irq` one clock later, and pending device 0 always wins the encoder. A valid ID never names the hole at bit 3. A held request keeps its status bit set, set-bit writes land in the enable register exactly, and an acknowledge with nothing pending always produces the spurious pulse. Only the bench scenarios show the full priority walk down to the core as enables are cleared one by one. They also show that a masked request stays silent, that status bits stay sticky after the request drops until a write-one-to-clear, and that a reset in mid-run empties every register.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int DEF_N_SRC = 5;
  localparam logic [DEF_N_SRC-1:0] DEF_SRC_MASK = 5'b10111;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_ENABLE = 2'd1,
    RA_EN_SET = 2'd2,
    RA_EN_CLR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pci_irq_regs.sv
module pci_irq_regs
  import pci_irq_pkg::*;
#(
  parameter int N_SRC = DEF_N_SRC,
  parameter logic [N_SRC-1:0] SRC_MASK = DEF_SRC_MASK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             we,
  input  logic             re,
  input  logic [1:0]       addr,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] enable_q,
  output logic [N_SRC-1:0] rdata
);
  reg_addr_e addr_e;
  assign addr_e = reg_addr_e'(addr);

  logic [N_SRC-1:0] w1c;
  logic [N_SRC-1:0] en_d;

  always_comb begin
    w1c  = (we && addr_e == RA_STATUS) ? wdata : '0;
    en_d = enable_q;
    if (we) begin
      unique case (addr_e)
        RA_ENABLE: en_d = wdata;
        RA_EN_SET: en_d = enable_q | wdata;
        RA_EN_CLR: en_d = enable_q & ~wdata;
        default:   en_d = enable_q;
      endcase
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) begin
          status_q[i] <= 1'b0;
          enable_q[i] <= 1'b0;
        end else begin
          status_q[i] <= (status_q[i] & ~w1c[i]) | irq_req[i];
          enable_q[i] <= en_d[i];
        end
      end
    end else begin : g_hole
      assign status_q[i] = 1'b0;
      assign enable_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= (addr_e == RA_STATUS) ? status_q : enable_q;
    end
  end
endmodule

// File: rtl/pci_irq_prio.sv
module pci_irq_prio #(
  parameter int N_SRC = 5,
  parameter int ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pending,
  output logic             any,
  output logic [ID_W-1:0]  id
);
  always_comb begin
    any = 1'b0;
    id  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        any = 1'b1;
        id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pci_irq_aggr.sv
module pci_irq_aggr
  import pci_irq_pkg::*;
#(
  parameter int N_SRC = DEF_N_SRC,
  parameter logic [N_SRC-1:0] SRC_MASK = DEF_SRC_MASK,
  localparam int ID_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  input  logic             int_ack,
  output logic             cpu_irq,
  output logic             src_valid,
  output logic [ID_W-1:0]  src_id,
  output logic             spurious
);
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] pending;
  logic             any_pend;
  logic [ID_W-1:0]  win_id;

  pci_irq_regs #(.N_SRC(N_SRC), .SRC_MASK(SRC_MASK)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .we       (reg_we),
    .re       (reg_re),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .status_q (status_q),
    .enable_q (enable_q),
    .rdata    (reg_rdata)
  );

  assign pending = status_q & enable_q;

  pci_irq_prio #(.N_SRC(N_SRC), .ID_W(ID_W)) u_prio (
    .pending (pending),
    .any     (any_pend),
    .id      (win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      src_valid <= 1'b0;
      src_id    <= '0;
      spurious  <= 1'b0;
    end else begin
      cpu_irq   <= |pending;
      src_valid <= any_pend;
      src_id    <= win_id;
      spurious  <= int_ack & ~any_pend;
    end
  end
endmodule

// File: rtl/pci_irq_aggr_chk.sv
module pci_irq_aggr_chk #(
  parameter int N_SRC = 5,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] irq_req,
  input logic [N_SRC-1:0] status_q,
  input logic [N_SRC-1:0] enable_q,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [N_SRC-1:0] reg_wdata,
  input logic [N_SRC-1:0] reg_rdata,
  input logic             int_ack,
  input logic             cpu_irq,
  input logic             src_valid,
  input logic [ID_W-1:0]  src_id,
  input logic             spurious
);
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[3] == 1'b0); // R2
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    irq_req[0] |=> status_q[0]); // R3
  AST_PEND_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & enable_q)) |=> cpu_irq); // R4
  AST_NO_PEND_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & enable_q)) |=> (!cpu_irq && !src_valid)); // R6
  AST_DEV0_WINS: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && enable_q[0]) |=> (src_valid && src_id == '0)); // R5
  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> (src_id != 3 && src_id < N_SRC)); // R5
  AST_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd2) |=>
      (enable_q == (($past(enable_q) | $past(reg_wdata)) & 5'b10111))); // R7
  AST_SPUR_ACK: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !(|(status_q & enable_q))) |=> spurious); // R10
  AST_SPUR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !int_ack |=> !spurious); // R10
endmodule

bind pci_irq_aggr pci_irq_aggr_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_req   (irq_req),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .int_ack   (int_ack),
  .cpu_irq   (cpu_irq),
  .src_valid (src_valid),
  .src_id    (src_id),
  .spurious  (spurious)
);

// File: tb/test_pci_irq_aggr.sv
module test_pci_irq_aggr;
  localparam int CLK_PERIOD = 10;
  localparam int F_IRQ = 0, F_VAL = 1, F_ID = 2, F_SPUR = 3, F_RD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] irq_req = '0;
  logic       reg_we = 1'b0, reg_re = 1'b0, int_ack = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic       cpu_irq, src_valid, spurious;
  logic [2:0] src_id;

  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int at; int fld; int val; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pci_irq_aggr i_pci_irq_aggr (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_ack(int_ack), .cpu_irq(cpu_irq), .src_valid(src_valid),
    .src_id(src_id), .spurious(spurious)
  );

  function automatic int actual(int fld);
    case (fld)
      F_IRQ:  return int'(cpu_irq);
      F_VAL:  return int'(src_valid);
      F_ID:   return int'(src_id);
      F_SPUR: return int'(spurious);
      default: return int'(reg_rdata);
    endcase
  endfunction

  // monitor: pops scoreboard entries that fall due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (actual(sb[i].fld) != sb[i].val) begin
          failures++;
          $display("FAIL %s field=%0d actual=%0d expected=%0d",
                   sb[i].tag, sb[i].fld, actual(sb[i].fld), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push(int dly, int fld, int val, string tag);
    exp_t e;
    e.at = cyc + dly; e.fld = fld; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [4:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, int e, string tag);
    push(1, F_RD, e, tag);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic chk_out(int irq, int val, int id, string tag);
    push(1, F_IRQ, irq, tag);
    push(1, F_VAL, val, tag);
    if (val != 0) push(1, F_ID, id, tag);
    @(negedge clk);
  endtask

  task automatic ack(int spur, string tag);
    push(1, F_SPUR, spur, tag);
    push(2, F_SPUR, 0, tag);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    push(1, F_SPUR, 0, "R1 spurious after reset");
    push(1, F_RD, 0, "R1 rdata after reset");
    chk_out(0, 0, 0, "R1 outputs after reset");
    rd(2'd1, 0, "R1 enable after reset");
    rd(2'd0, 0, "R1 status after reset");
    // R4: masked request is not pending
    irq_req = 5'b00010; idle(2);
    rd(2'd0, 5'h02, "R3 status follows request");
    chk_out(0, 0, 0, "R4 masked request silent");
    // R7: set-bit
    wr(2'd2, 5'h02);
    rd(2'd1, 5'h02, "R7 set-bit enable");
    idle(1);
    chk_out(1, 1, 1, "R4 unmasked device1");
    // R9 / R2 / R5
    irq_req = 5'b11111;
    wr(2'd1, 5'h1F);
    rd(2'd1, 5'h17, "R9 R2 full write readback");
    rd(2'd0, 5'h17, "R2 status hole zero");
    chk_out(1, 1, 0, "R5 device0 first");
    // R8: clear walk
    wr(2'd3, 5'h01); rd(2'd1, 5'h16, "R8 clear bit0");
    chk_out(1, 1, 1, "R5 device1 next");
    wr(2'd3, 5'h02); rd(2'd1, 5'h14, "R8 clear bit1");
    chk_out(1, 1, 2, "R5 device2 next");
    wr(2'd3, 5'h04); rd(2'd1, 5'h10, "R8 clear bit2");
    chk_out(1, 1, 4, "R5 core last");
    wr(2'd2, 5'h08); rd(2'd1, 5'h10, "R2 write to hole ignored");
    wr(2'd2, 5'h01); rd(2'd1, 5'h11, "R7 set only bit0");
    chk_out(1, 1, 0, "R5 device0 over core");
    // R3: level hold and sticky clear
    wr(2'd0, 5'h1F); idle(1);
    rd(2'd0, 5'h17, "R3 held request survives clear");
    irq_req = '0; idle(2);
    rd(2'd0, 5'h17, "R3 status sticky after release");
    wr(2'd0, 5'h01); rd(2'd0, 5'h16, "R3 write one clears bit0");
    chk_out(1, 1, 4, "R4 only core pending");
    wr(2'd0, 5'h1F); rd(2'd0, 5'h00, "R3 all cleared");
    chk_out(0, 0, 0, "R6 nothing pending");
    // R10
    ack(1, "R10 spurious ack");
    irq_req = 5'b00001; idle(2);
    ack(0, "R10 ack with pending");
    chk_out(1, 1, 0, "R5 device0 pending");
    // R2: request on the hole
    irq_req = '0; wr(2'd0, 5'h1F);
    irq_req = 5'b01000; idle(2);
    rd(2'd0, 5'h00, "R2 hole request ignored");
    chk_out(0, 0, 0, "R2 hole no irq");
    // R1: mid-run reset
    irq_req = 5'b10000; wr(2'd1, 5'h1F); idle(2);
    irq_req = '0; rst = 1'b1; idle(2); rst = 1'b0;
    rd(2'd1, 0, "R1 enable after mid reset");
    rd(2'd0, 0, "R1 status after mid reset");
    chk_out(0, 0, 0, "R1 outputs after mid reset");
    idle(3);
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule